// File: doc/BRIEF.md
# Dual-Sync Serial Port with Word FIFOs

This block is a full-duplex synchronous serial port that moves 16-bit words. Transmit and receive each own a 16-entry word FIFO and a separate frame-sync line. A transmit frame and a receive frame start independently, so the two directions can carry different amounts of traffic. The register side pushes words into the transmit FIFO and pops words from the receive FIFO. It sees fill levels, full and empty flags, two threshold interrupts and one-cycle error pulses.

In master mode the port makes the bit clock from the system clock through a programmable divider. While a direction is enabled, the port issues that direction's frame sync once every 16 bit periods. In slave mode the bit clock, both frame syncs and the data input come from outside. They pass through a two-stage synchronizer and edge detection. The master-mode outputs then stay low. On every bit-clock edge, both modes feed the same transmit and receive shift engines. Data changes on the falling edge of the bit clock. Frame syncs and incoming data are sampled on the rising edge.

Top module: `sport_duplex`

## Requirements
- R1: After reset both FIFOs are empty with level 0, the full flags are low, and `sdo`, `sck_o`, `txfs_o` and `rxfs_o` are low. The receive-half interrupt is low and the transmit-half interrupt is high.
- R2: Each FIFO holds 16 words of 16 bits and returns them first in, first out. Its level counts the stored words. A push to a full FIFO and a pop from an empty FIFO change nothing.
- R3: `irq_tx_half` is high exactly while the transmit FIFO holds 8 or fewer words.
- R4: `irq_rx_half` is high exactly while the receive FIFO holds 8 or more words.
- R5: In master mode `sck_o` toggles every `clk_div`+1 system cycles, so one bit period is 2*(`clk_div`+1) cycles.
- R6: In master mode, while `tx_en` (or `rx_en`) is high, `txfs_o` (or `rxfs_o`) goes high for exactly one bit period once every 16 bit periods. A disabled direction gives no pulses.
- R7: A transmit frame sync sampled high on a rising edge pops one word. The word is driven on `sdo` most significant bit first, one bit per falling edge, over the next 16 bit periods. With no frame active, `sdo` is driven low.
- R8: A receive frame sync sampled high on a rising edge starts a frame. `sdi` is sampled on each of the next 16 rising edges, first bit most significant, and the word is pushed into the receive FIFO.
- R9: If the transmit FIFO is empty at the start of a transmit frame, the frame sends 16 zeros and `tx_underrun` pulses high for one cycle.
- R10: If a received word completes while the receive FIFO is full, the word is dropped and `rx_overrun` pulses high for one cycle.
- R11: In slave mode `sck_o`, `txfs_o` and `rxfs_o` stay low. Framing and data come from `sck_i`, `txfs_i`, `rxfs_i` and `sdi` after two synchronizer stages.
- R12: A frame on one direction leaves the other direction's FIFO unchanged: a receive-only frame pops nothing, and a transmit-only frame pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: generate bit clock and frame syncs; 0: accept them |
| clk_div | input | 8 | Master half-bit-period length minus one, in system cycles |
| tx_en | input | 1 | Master mode: issue transmit frame syncs |
| rx_en | input | 1 | Master mode: issue receive frame syncs |
| tx_push | input | 1 | Write `tx_wdata` into the transmit FIFO |
| tx_wdata | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 5 | Words held in the transmit FIFO |
| irq_tx_half | output | 1 | Transmit FIFO at or below half |
| tx_underrun | output | 1 | One-cycle pulse: frame started with empty transmit FIFO |
| rx_pop | input | 1 | Remove the head word from the receive FIFO |
| rx_rdata | output | 16 | Head word of the receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 5 | Words held in the receive FIFO |
| irq_rx_half | output | 1 | Receive FIFO at or above half |
| rx_overrun | output | 1 | One-cycle pulse: received word dropped |
| sck_i | input | 1 | Bit clock from outside (slave mode) |
| sck_o | output | 1 | Bit clock driven out (master mode) |
| txfs_i | input | 1 | Transmit frame sync from outside (slave mode) |
| txfs_o | output | 1 | Transmit frame sync driven out (master mode) |
| rxfs_i | input | 1 | Receive frame sync from outside (slave mode) |
| rxfs_o | output | 1 | Receive frame sync driven out (master mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
A bad FIFO pointer or count shows on the next cycle at `tx_level`, `rx_level`, the flags and the interrupts. A wrongly ordered word appears at `rx_rdata` when it reaches the head of the queue. A transmit shift or bit-count fault shows on `sdo` within one bit period of the frame start. A receive-side fault shows only when the word is pushed, 16 bit periods after the frame sync, as a wrong value or a missing level step. Divider and frame-phase faults show on `sck_o` and the sync outputs within one bit period or one frame, and the bench measures them in system cycles.

// File: rtl/sport_pkg.sv
package sport_pkg;
   // one-cycle strobes marking bit-clock transitions
   typedef struct packed {
      logic rise;
      logic fall;
   } sck_ev_t;
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sport_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= g_stage[g-1].r;
      end
   end

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/sport_fifo.sv
module sport_fifo #(
   parameter int  DW    = 16,
   parameter int  DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = $clog2(DEPTH + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("sport_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [DW-1:0] store [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_wr, do_rd;

   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
   assign do_wr = push & ~full;
   assign do_rd = pop & ~empty;
   assign rdata = store[rp];

   always_ff @(posedge clk)
      if (do_wr) store[wp] <= wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sport_bitclk.sv
module sport_bitclk
   import sport_pkg::*;
#(
   parameter int  DW   = 16,
   parameter int  DIVW = 8,
   localparam int PW   = $clog2(DW)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            master,
   input  logic [DIVW-1:0] div,
   input  logic            tx_en,
   input  logic            rx_en,
   input  logic            sck_s,
   input  logic            txfs_s,
   input  logic            rxfs_s,
   output logic            sck_o,
   output logic            txfs_o,
   output logic            rxfs_o,
   output sck_ev_t         ev,
   output logic            txfs_use,
   output logic            rxfs_use
);
   logic [DIVW-1:0] div_cnt;
   logic [PW-1:0]   ph;
   logic            sck_prev, tick, last;

   assign tick = master & (div_cnt == div);
   assign last = (ph == PW'(DW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt  <= '0;
         sck_o    <= 1'b0;
         ph       <= '0;
         txfs_o   <= 1'b0;
         rxfs_o   <= 1'b0;
         sck_prev <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         if (!master) begin
            div_cnt <= '0;
            sck_o   <= 1'b0;
            ph      <= '0;
            txfs_o  <= 1'b0;
            rxfs_o  <= 1'b0;
         end else if (tick) begin
            div_cnt <= '0;
            sck_o   <= ~sck_o;
            if (sck_o) begin
               // falling edge: advance frame phase, launch syncs
               ph     <= last ? '0 : ph + 1'b1;
               txfs_o <= tx_en & last;
               rxfs_o <= rx_en & last;
            end
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end

   always_comb begin
      if (master) begin
         ev.rise  = tick & ~sck_o;
         ev.fall  = tick & sck_o;
         txfs_use = txfs_o;
         rxfs_use = rxfs_o;
      end else begin
         ev.rise  = sck_s & ~sck_prev;
         ev.fall  = ~sck_s & sck_prev;
         txfs_use = txfs_s;
         rxfs_use = rxfs_s;
      end
   end
endmodule

// File: rtl/sport_duplex.sv
module sport_duplex
   import sport_pkg::*;
#(
   parameter int  DW          = 16,
   parameter int  DEPTH       = 16,
   parameter int  DIVW        = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int LW          = $clog2(DEPTH + 1)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            master,
   input  logic [DIVW-1:0] clk_div,
   input  logic            tx_en,
   input  logic            rx_en,
   input  logic            tx_push,
   input  logic [DW-1:0]   tx_wdata,
   output logic            tx_full,
   output logic            tx_empty,
   output logic [LW-1:0]   tx_level,
   output logic            irq_tx_half,
   output logic            tx_underrun,
   input  logic            rx_pop,
   output logic [DW-1:0]   rx_rdata,
   output logic            rx_full,
   output logic            rx_empty,
   output logic [LW-1:0]   rx_level,
   output logic            irq_rx_half,
   output logic            rx_overrun,
   input  logic            sck_i,
   output logic            sck_o,
   input  logic            txfs_i,
   output logic            txfs_o,
   input  logic            rxfs_i,
   output logic            rxfs_o,
   input  logic            sdi,
   output logic            sdo
);
   localparam int HALF = DEPTH / 2;
   localparam int CW   = $clog2(DW + 1);

   if (DW < 2) begin : g_bad_dw
      $error("sport_duplex: DW must be at least 2");
   end
   if (DIVW < 1) begin : g_bad_divw
      $error("sport_duplex: DIVW must be at least 1");
   end

   // slave-side inputs, all delayed equally so their alignment holds
   logic [3:0] pin_s;
   sport_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .d   ({sck_i, txfs_i, rxfs_i, sdi}),
      .q   (pin_s)
   );

   sck_ev_t ev;
   logic    txfs_use, rxfs_use, sdi_use;

   sport_bitclk #(.DW(DW), .DIVW(DIVW)) u_bitclk (
      .clk (clk), .rst_n (rst_n), .master (master), .div (clk_div),
      .tx_en (tx_en), .rx_en (rx_en),
      .sck_s (pin_s[3]), .txfs_s (pin_s[2]), .rxfs_s (pin_s[1]),
      .sck_o (sck_o), .txfs_o (txfs_o), .rxfs_o (rxfs_o),
      .ev (ev), .txfs_use (txfs_use), .rxfs_use (rxfs_use)
   );

   // master timing is internal, so its data input needs no extra delay
   assign sdi_use = master ? sdi : pin_s[0];

   // ---------------- transmit ----------------
   logic [DW-1:0] tx_head, tx_sh;
   logic [CW-1:0] tx_cnt;
   logic          tx_start, tx_take;

   assign tx_start = ev.rise & txfs_use;
   assign tx_take  = tx_start & ~tx_empty;

   sport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk (clk), .rst_n (rst_n),
      .push (tx_push), .wdata (tx_wdata),
      .pop (tx_take), .rdata (tx_head),
      .full (tx_full), .empty (tx_empty), .level (tx_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh       <= '0;
         tx_cnt      <= '0;
         sdo         <= 1'b0;
         tx_underrun <= 1'b0;
      end else begin
         tx_underrun <= tx_start & tx_empty;
         if (tx_start) begin
            tx_cnt <= CW'(DW);
            tx_sh  <= tx_empty ? '0 : tx_head;
         end else if (ev.fall) begin
            if (tx_cnt != '0) begin
               sdo    <= tx_sh[DW-1];
               tx_sh  <= {tx_sh[DW-2:0], 1'b0};
               tx_cnt <= tx_cnt - 1'b1;
            end else begin
               sdo <= 1'b0;
            end
         end
      end
   end

   // ---------------- receive ----------------
   logic [DW-2:0] rx_sh;
   logic [DW-1:0] rx_word;
   logic [CW-1:0] rx_cnt;
   logic          rx_done;

   assign rx_word = {rx_sh, sdi_use};
   assign rx_done = ev.rise & (rx_cnt == CW'(1));

   sport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk (clk), .rst_n (rst_n),
      .push (rx_done), .wdata (rx_word),
      .pop (rx_pop), .rdata (rx_rdata),
      .full (rx_full), .empty (rx_empty), .level (rx_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh      <= '0;
         rx_cnt     <= '0;
         rx_overrun <= 1'b0;
      end else begin
         rx_overrun <= rx_done & rx_full;
         if (ev.rise) begin
            if (rx_cnt != '0) begin
               rx_sh  <= rx_word[DW-2:0];
               rx_cnt <= rx_cnt - 1'b1;
            end
            if (rxfs_use) rx_cnt <= CW'(DW);
         end
      end
   end

   assign irq_tx_half = (tx_level <= LW'(HALF));
   assign irq_rx_half = (rx_level >= LW'(HALF));
endmodule

// File: rtl/sport_duplex_chk.sv
module sport_duplex_chk #(
   parameter int DEPTH = 16,
   parameter int LW    = 5
)(
   input logic          clk,
   input logic          rst_n,
   input logic          master,
   input logic          sck_o,
   input logic          txfs_o,
   input logic          rxfs_o,
   input logic [LW-1:0] tx_level,
   input logic [LW-1:0] rx_level,
   input logic          tx_full,
   input logic          tx_empty,
   input logic          rx_full,
   input logic          irq_tx_half,
   input logic          irq_rx_half,
   input logic          tx_underrun,
   input logic          rx_overrun
);
   // R2
   tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LW'(DEPTH));
   // R2
   tx_level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == $past(tx_level)) || (tx_level == $past(tx_level) + 1'b1) ||
      (tx_level + 1'b1 == $past(tx_level)));
   // R2
   rx_level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == $past(rx_level)) || (rx_level == $past(rx_level) + 1'b1) ||
      (rx_level + 1'b1 == $past(rx_level)));
   // R2
   tx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |-> !tx_empty);
   // R3
   tx_half_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |-> !irq_tx_half);
   // R4
   rx_half_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> irq_rx_half);
   // R9
   underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |-> $past(tx_empty));
   // R10
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> $past(rx_full));
   // R11
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master |=> (!sck_o && !txfs_o && !rxfs_o));
endmodule

bind sport_duplex sport_duplex_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
   .clk (clk), .rst_n (rst_n), .master (master),
   .sck_o (sck_o), .txfs_o (txfs_o), .rxfs_o (rxfs_o),
   .tx_level (tx_level), .rx_level (rx_level),
   .tx_full (tx_full), .tx_empty (tx_empty), .rx_full (rx_full),
   .irq_tx_half (irq_tx_half), .irq_rx_half (irq_rx_half),
   .tx_underrun (tx_underrun), .rx_overrun (rx_overrun)
);

// File: tb/sport_duplex_tb.sv
`timescale 1ns/1ps
module sport_duplex_tb;
   localparam int DW = 16, DEPTH = 16, DIV = 1, HP = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic master = 1'b0, tx_en = 1'b0, rx_en = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0]  clk_div = 8'(DIV);
   logic [15:0] tx_wdata = '0, rx_rdata;
   logic tx_full, tx_empty, irq_tx_half, tx_underrun;
   logic rx_full, rx_empty, irq_rx_half, rx_overrun;
   logic [4:0] tx_level, rx_level;
   logic sck_i = 1'b0, txfs_i = 1'b0, rxfs_i = 1'b0, sdi_drv = 1'b0, loop = 1'b0;
   logic sck_o, txfs_o, rxfs_o, sdi, sdo;

   assign sdi = loop ? sdo : sdi_drv;

   sport_duplex u_dut (
      .clk (clk), .rst_n (rst_n), .master (master), .clk_div (clk_div),
      .tx_en (tx_en), .rx_en (rx_en), .tx_push (tx_push), .tx_wdata (tx_wdata),
      .tx_full (tx_full), .tx_empty (tx_empty), .tx_level (tx_level),
      .irq_tx_half (irq_tx_half), .tx_underrun (tx_underrun),
      .rx_pop (rx_pop), .rx_rdata (rx_rdata), .rx_full (rx_full), .rx_empty (rx_empty),
      .rx_level (rx_level), .irq_rx_half (irq_rx_half), .rx_overrun (rx_overrun),
      .sck_i (sck_i), .sck_o (sck_o), .txfs_i (txfs_i), .txfs_o (txfs_o),
      .rxfs_i (rxfs_i), .rxfs_o (rxfs_o), .sdi (sdi), .sdo (sdo)
   );

   always #2.5 clk = ~clk;

   int total = 0, bad = 0, ucnt = 0, ocnt = 0;
   bit finished = 1'b0;
   logic [15:0] words [16];

   always @(posedge clk) begin
      if (tx_underrun) ucnt++;
      if (rx_overrun)  ocnt++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit m);
      rst_n = 1'b0; master = m; tx_en = 0; rx_en = 0; tx_push = 0; rx_pop = 0;
      loop = 0; sdi_drv = 0; sck_i = 0; txfs_i = 0; rxfs_i = 0; clk_div = 8'(DIV);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push_tx(input logic [15:0] w);
      tx_push = 1'b1; tx_wdata = w;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pop_rx();
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   // bench acts as bit-clock master: 17 rising edges, sync on the first
   task automatic slave_frame(input bit do_tx, input bit do_rx,
                              input logic [15:0] rxw, output logic [15:0] got);
      got = '0;
      for (int i = 0; i <= 16; i++) begin
         sck_i  = 1'b0;
         txfs_i = (i == 0) && do_tx;
         rxfs_i = (i == 0) && do_rx;
         sdi_drv = (i >= 1) ? rxw[16-i] : 1'b0;
         repeat (HP) @(negedge clk);
         if (i >= 1) got[16-i] = sdo;
         sck_i = 1'b1;
         repeat (HP) @(negedge clk);
      end
      sck_i = 1'b0; txfs_i = 0; rxfs_i = 0; sdi_drv = 0;
      repeat (HP) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      check(tx_empty && rx_empty && !tx_full && !rx_full, "R1 empty flags",
            {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
      check(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
      check(irq_tx_half && !irq_rx_half, "R1 irqs", {irq_tx_half, irq_rx_half}, 2'b10);
      check({sdo, sck_o, txfs_o, rxfs_o} == 4'b0, "R1 serial outputs",
            {sdo, sck_o, txfs_o, rxfs_o}, 0);
   endtask

   task automatic t_fifo_levels();
      for (int i = 0; i < 16; i++) begin
         words[i] = 16'hC35A ^ 16'(i * 16'h0F1);
         push_tx(words[i]);
         check(tx_level == 5'(i + 1), "R2 tx level", tx_level, i + 1);
         check(irq_tx_half == (i + 1 <= 8), "R3 tx half irq", irq_tx_half, (i + 1 <= 8));
      end
      check(tx_full, "R2 tx full", tx_full, 1);
      push_tx(16'hFFFF);
      check(tx_level == 5'd16, "R2 push when full ignored", tx_level, 16);
      pop_rx();
      check(rx_level == 0 && rx_empty, "R2 pop when empty ignored", rx_level, 0);
   endtask

   task automatic t_master_loop();
      int u0, o0, t0, t1, fs_w, fs_a, fs_b, n;
      logic prev;
      u0 = ucnt; o0 = ocnt;
      loop = 1'b1; master = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
      t0 = -1; t1 = -1; prev = sck_o;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (sck_o && !prev) begin
            if (t0 < 0) t0 = k; else if (t1 < 0) t1 = k;
         end
         prev = sck_o;
      end
      check(t1 - t0 == 2 * (DIV + 1), "R5 sck period", t1 - t0, 2 * (DIV + 1));
      fs_a = -1; fs_b = -1; fs_w = 0; prev = txfs_o;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (txfs_o && !prev) begin
            if (fs_a < 0) fs_a = k; else if (fs_b < 0) fs_b = k;
         end
         if (txfs_o && fs_b < 0) fs_w++;
         check(txfs_o == rxfs_o, "R6 syncs aligned", rxfs_o, txfs_o);
         prev = txfs_o;
      end
      check(fs_w == 2 * (DIV + 1), "R6 sync width", fs_w, 2 * (DIV + 1));
      check(fs_b - fs_a == 16 * 2 * (DIV + 1), "R6 sync spacing", fs_b - fs_a, 32 * (DIV + 1));
      n = 0;
      while (ocnt == o0 && n < 4000) begin @(negedge clk); n++; end
      tx_en = 1'b0; rx_en = 1'b0;
      repeat (150) @(negedge clk);
      check(rx_level == 5'd16 && rx_full, "R2 rx fills to 16", rx_level, 16);
      check(tx_empty, "R7 all words sent", tx_empty, 1);
      check(ucnt > u0, "R9 underrun pulse", ucnt - u0, 1);
      check(ocnt > o0, "R10 overrun pulse", ocnt - o0, 1);
      n = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (txfs_o || rxfs_o) n++;
      end
      check(n == 0, "R6 no sync when disabled", n, 0);
      for (int i = 0; i < 16; i++) begin
         check(rx_rdata == words[i], "R8 loopback word order", rx_rdata, words[i]);
         check(irq_rx_half == (16 - i >= 8), "R4 rx half irq", irq_rx_half, (16 - i >= 8));
         pop_rx();
      end
      check(rx_empty && !irq_rx_half, "R10 overflow words dropped", rx_level, 0);
   endtask

   task automatic t_master_rx_only();
      int u0, ntx, nrx;
      logic prev;
      do_reset(1'b1);
      u0 = ucnt; sdi_drv = 1'b1; rx_en = 1'b1;
      ntx = 0; nrx = 0; prev = rxfs_o;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (txfs_o) ntx++;
         if (rxfs_o && !prev) nrx++;
         prev = rxfs_o;
      end
      rx_en = 1'b0;
      repeat (100) @(negedge clk);
      check(ntx == 0, "R6 tx sync idle while tx disabled", ntx, 0);
      check(nrx >= 1, "R6 rx sync issued", nrx, 1);
      check(rx_level >= 1 && rx_rdata == 16'hFFFF, "R8 ones received", rx_rdata, 16'hFFFF);
      check(ucnt == u0, "R12 no tx frame on rx-only traffic", ucnt - u0, 0);
   endtask

   task automatic t_slave();
      logic [15:0] got;
      int u0, n;
      do_reset(1'b0);
      n = 0;
      push_tx(16'hA5C3);
      push_tx(16'h1234);
      slave_frame(1'b1, 1'b1, 16'h9F06, got);
      if (sck_o || txfs_o || rxfs_o) n++;
      check(n == 0, "R11 master outputs low in slave mode", n, 0);
      check(got == 16'hA5C3, "R7 msb-first word on sdo", got, 16'hA5C3);
      check(rx_level == 1 && rx_rdata == 16'h9F06, "R8 slave receive", rx_rdata, 16'h9F06);
      check(tx_level == 1, "R7 one word popped", tx_level, 1);
      slave_frame(1'b0, 1'b1, 16'h0F0F, got);
      check(tx_level == 1, "R12 rx-only frame leaves tx fifo", tx_level, 1);
      check(got == 16'h0, "R7 sdo low when idle", got, 0);
      check(rx_level == 2, "R8 second word pushed", rx_level, 2);
      slave_frame(1'b1, 1'b0, 16'hFFFF, got);
      check(got == 16'h1234, "R7 second word sent", got, 16'h1234);
      check(rx_level == 2, "R12 tx-only frame leaves rx fifo", rx_level, 2);
      u0 = ucnt;
      slave_frame(1'b1, 1'b0, 16'h0, got);
      check(got == 16'h0, "R9 zeros on underrun", got, 0);
      check(ucnt == u0 + 1, "R9 single underrun pulse", ucnt - u0, 1);
      pop_rx();
      check(rx_rdata == 16'h0F0F, "R2 rx order", rx_rdata, 16'h0F0F);
   endtask

   initial begin
      t_reset();
      t_fifo_levels();
      t_master_loop();
      t_master_rx_only();
      t_slave();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule